// File: doc/BRIEF.md
# Lane-Splittable Add/Subtract and Logic Unit

This block is a 48-bit arithmetic and bitwise logic stage with a registered output. Its carry chain can be cut into narrower independent lanes. A build-time parameter sets the lane layout: one 48-bit lane, two 24-bit lanes or four 12-bit lanes. Every lane runs the same opcode in a given cycle. Carries never pass from one lane into the next, so one wide adder can serve several small additions at once.

The arithmetic operations are add, subtract and accumulate. Accumulate folds the previous registered result back in as one operand. The bitwise operations always act on the whole word, and the lane layout has no effect on them. Each active lane reports its own carry-out through a registered carry vector. Unused positions in that vector stay zero.

Top module: `simd_alu48`

## Requirements
- R1: Parameter `LANE_MODE` chooses one 48-bit lane (`LANES_1X48`, the default), two 24-bit lanes (`LANES_2X24`) or four 12-bit lanes (`LANES_4X12`); lane i covers bits [(i+1)*W-1 : i*W], and in arithmetic no carry crosses from one lane into the next.
- R2: With `op` = 3'b000 (add), each lane holds z + x + c, where c is `carry_in` for lane 0 and 0 for every higher lane.
- R3: With `op` = 3'b001 (subtract), each lane holds z − x in two's complement, formed as z + ~x + c; c is the inverse of `carry_in` for lane 0, so `carry_in` acts as a borrow, and c is 1 for every higher lane.
- R4: With `op` = 3'b010 (accumulate), each lane holds the previous `result` lane + x + c, with c chosen as for add.
- R5: For an arithmetic op, `carry_out[i]` is the carry leaving the top bit of lane i (for subtract, 1 means no borrow); bits at index number-of-lanes and above read 0.
- R6: Logic ops act bitwise on the full 48 bits and give the same value in every lane mode: 3'b011 z&x, 3'b100 z|x, 3'b101 z^x, 3'b110 ~(z^x), 3'b111 z&~x. After any of them `carry_out` is all zero.
- R7: `result` and `carry_out` are registered: operands presented with `ce` high before a rising edge appear just after that edge.
- R8: While `ce` is low and `rst` is low, `result` and `carry_out` keep their values.
- R9: A high `rst` at a rising edge clears `result` and `carry_out` to zero, regardless of `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the output registers |
| op | input | 3 | Operation code shared by all lanes |
| z_in | input | 48 | Left operand (minuend for subtract) |
| x_in | input | 48 | Right operand |
| carry_in | input | 1 | Carry into lane 0 (borrow for subtract) |
| result | output | 48 | Registered result word |
| carry_out | output | 4 | Registered per-lane carry-out, bit i for lane i |

## Verification
The bench builds three copies of the block side by side, one for each lane mode, and drives the same stimulus into all three. Operands with long runs of ones therefore show, in a single cycle, where the single-lane build carries across 12- and 24-bit boundaries and where the split builds stop the carry. The two-lane build also exercises carry-out positions that are present but unused. Accumulate chains and logic patterns are compared across the three builds, which shows that the lane setting changes only arithmetic results.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [1:0] {
    LANES_1X48 = 2'd0,
    LANES_2X24 = 2'd1,
    LANES_4X12 = 2'd2
  } lane_mode_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_ACC  = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_XOR  = 3'b101,
    OP_XNOR = 3'b110,
    OP_ANDN = 3'b111
  } alu_op_e;

  function automatic int lane_count(lane_mode_e mode);
    case (mode)
      LANES_1X48: return 1;
      LANES_2X24: return 2;
      default:    return 4;
    endcase
  endfunction

  function automatic logic op_is_arith(alu_op_e o);
    return (o == OP_ADD) || (o == OP_SUB) || (o == OP_ACC);
  endfunction

endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
endmodule

// File: rtl/simd_carry_split.sv
module simd_carry_split #(
  parameter int WIDTH = 48,
  parameter int LANES = 1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin_low,
  input  logic             cin_upper,
  output logic [WIDTH-1:0] sum,
  output logic [LANES-1:0] lane_cout
);
  localparam int LW = WIDTH / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic c_start;
    if (g == 0) begin : g_first
      assign c_start = cin_low;
    end else begin : g_rest
      assign c_start = cin_upper;
    end
    simd_lane_add #(.W(LW)) u_add (
      .a    (a[g*LW +: LW]),
      .b    (b[g*LW +: LW]),
      .cin  (c_start),
      .sum  (sum[g*LW +: LW]),
      .cout (lane_cout[g])
    );
  end
endmodule

// File: rtl/simd_operand_sel.sv
module simd_operand_sel
  import simd_alu_pkg::*;
#(
  parameter int WIDTH = 48
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] z_in,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] acc,
  input  logic             carry_in,
  output logic [WIDTH-1:0] a_side,
  output logic [WIDTH-1:0] b_side,
  output logic             cin_low,
  output logic             cin_upper
);
  always_comb begin
    a_side    = z_in;
    b_side    = x_in;
    cin_low   = carry_in;
    cin_upper = 1'b0;
    case (op)
      OP_SUB: begin
        b_side    = ~x_in;
        cin_low   = ~carry_in;
        cin_upper = 1'b1;
      end
      OP_ACC: a_side = acc;
      default: ;
    endcase
  end
endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
  import simd_alu_pkg::*;
#(
  parameter int WIDTH = 48
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] z_in,
  input  logic [WIDTH-1:0] x_in,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = z_in & x_in;
      OP_OR:   y = z_in | x_in;
      OP_XOR:  y = z_in ^ x_in;
      OP_XNOR: y = ~(z_in ^ x_in);
      OP_ANDN: y = z_in & ~x_in;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_alu48.sv
module simd_alu48
  import simd_alu_pkg::*;
#(
  parameter int         WIDTH     = 48,
  parameter int         MAX_LANES = 4,
  parameter lane_mode_e LANE_MODE = LANES_1X48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [2:0]           op,
  input  logic [WIDTH-1:0]     z_in,
  input  logic [WIDTH-1:0]     x_in,
  input  logic                 carry_in,
  output logic [WIDTH-1:0]     result,
  output logic [MAX_LANES-1:0] carry_out
);
  localparam int LANES = lane_count(LANE_MODE);

  alu_op_e              op_e;
  logic [WIDTH-1:0]     a_side, b_side, arith_sum, logic_y;
  logic                 cin_low, cin_upper, arith;
  logic [LANES-1:0]     lane_cout;
  logic [MAX_LANES-1:0] cout_ext;

  assign op_e  = alu_op_e'(op);
  assign arith = op_is_arith(op_e);

  simd_operand_sel #(.WIDTH(WIDTH)) u_sel (
    .op        (op_e),
    .z_in      (z_in),
    .x_in      (x_in),
    .acc       (result),
    .carry_in  (carry_in),
    .a_side    (a_side),
    .b_side    (b_side),
    .cin_low   (cin_low),
    .cin_upper (cin_upper)
  );

  simd_carry_split #(.WIDTH(WIDTH), .LANES(LANES)) u_split (
    .a         (a_side),
    .b         (b_side),
    .cin_low   (cin_low),
    .cin_upper (cin_upper),
    .sum       (arith_sum),
    .lane_cout (lane_cout)
  );

  simd_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op   (op_e),
    .z_in (z_in),
    .x_in (x_in),
    .y    (logic_y)
  );

  always_comb begin
    cout_ext = '0;
    cout_ext[LANES-1:0] = lane_cout;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= '0;
    end else if (ce) begin
      result    <= arith ? arith_sum : logic_y;
      carry_out <= arith ? cout_ext : '0;
    end
  end
endmodule

// File: rtl/simd_alu48_chk.sv
module simd_alu48_chk #(
  parameter int WIDTH     = 48,
  parameter int MAX_LANES = 4,
  parameter int LANES     = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ce,
  input logic [2:0]           op,
  input logic [WIDTH-1:0]     z_in,
  input logic [WIDTH-1:0]     x_in,
  input logic                 carry_in,
  input logic [WIDTH-1:0]     result,
  input logic [MAX_LANES-1:0] carry_out
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0 && carry_out == '0)); // R9

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(result) && $stable(carry_out))); // R8

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ce && op >= 3'b011) |=> carry_out == '0); // R6

  AST_XOR_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
    (ce && op == 3'b101) |=> result == ($past(z_in) ^ $past(x_in))); // R6

  AST_WIDE_ADD: assert property (@(posedge clk) disable iff (rst)
    (LANES == 1 && ce && op == 3'b000) |=>
      {carry_out[0], result} ==
        ({1'b0, $past(z_in)} + {1'b0, $past(x_in)} + {{WIDTH{1'b0}}, $past(carry_in)})); // R2

  AST_WIDE_ACC: assert property (@(posedge clk) disable iff (rst)
    (LANES == 1 && ce && op == 3'b010) |=>
      result == WIDTH'($past(result) + $past(x_in) + {{(WIDTH-1){1'b0}}, $past(carry_in)})); // R4
endmodule

bind simd_alu48 simd_alu48_chk #(
  .WIDTH(WIDTH), .MAX_LANES(MAX_LANES), .LANES(LANES)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .op(op), .z_in(z_in), .x_in(x_in),
  .carry_in(carry_in), .result(result), .carry_out(carry_out)
);

// File: tb/simd_alu48_test.sv
module simd_alu48_test;
  import simd_alu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 48;
  localparam int ML = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce  = 1'b0;
  logic [2:0]    op  = 3'b000;
  logic [W-1:0]  z   = '0;
  logic [W-1:0]  x   = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  res [3];
  logic [ML-1:0] co  [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_alu48 #(.LANE_MODE(LANES_1X48)) uut (
    .clk(clk), .rst(rst), .ce(ce), .op(op), .z_in(z), .x_in(x),
    .carry_in(cin), .result(res[0]), .carry_out(co[0]));
  simd_alu48 #(.LANE_MODE(LANES_2X24)) uut_w24 (
    .clk(clk), .rst(rst), .ce(ce), .op(op), .z_in(z), .x_in(x),
    .carry_in(cin), .result(res[1]), .carry_out(co[1]));
  simd_alu48 #(.LANE_MODE(LANES_4X12)) uut_w12 (
    .clk(clk), .rst(rst), .ce(ce), .op(op), .z_in(z), .x_in(x),
    .carry_in(cin), .result(res[2]), .carry_out(co[2]));

  typedef struct {
    logic [W-1:0]  r [3];
    logic [ML-1:0] c [3];
    string         req;
  } exp_t;

  exp_t          sb[$];
  logic [W-1:0]  m_res [3];
  logic [ML-1:0] m_co  [3];
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 0;

  function automatic void model(input int lanes, input logic [2:0] o,
                                input logic [W-1:0] zz, input logic [W-1:0] xx,
                                input logic ci, input logic [W-1:0] prev,
                                output logic [W-1:0] r, output logic [ML-1:0] c_o);
    int lw;
    logic [W-1:0] a, b;
    logic c;
    lw  = W / lanes;
    c_o = '0;
    r   = '0;
    case (o)
      3'b011: r = zz & xx;
      3'b100: r = zz | xx;
      3'b101: r = zz ^ xx;
      3'b110: r = ~(zz ^ xx);
      3'b111: r = zz & ~xx;
      default: begin
        a = (o == 3'b010) ? prev : zz;
        b = (o == 3'b001) ? ~xx : xx;
        c = (o == 3'b001) ? ~ci : ci;
        for (int i = 0; i < W; i++) begin
          if (i > 0 && (i % lw) == 0) begin
            c_o[i/lw - 1] = c;
            c = (o == 3'b001);
          end
          r[i] = a[i] ^ b[i] ^ c;
          c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        c_o[lanes-1] = c;
      end
    endcase
  endfunction

  task automatic step(input logic r_, input logic ce_, input logic [2:0] o,
                      input logic [W-1:0] zz, input logic [W-1:0] xx,
                      input logic ci, input string req);
    exp_t e;
    logic [W-1:0]  nr;
    logic [ML-1:0] nc;
    @(negedge clk);
    rst = r_; ce = ce_; op = o; z = zz; x = xx; cin = ci;
    for (int k = 0; k < 3; k++) begin
      if (r_) begin
        m_res[k] = '0;
        m_co[k]  = '0;
      end else if (ce_) begin
        model(1 << k, o, zz, xx, ci, m_res[k], nr, nc);
        m_res[k] = nr;
        m_co[k]  = nc;
      end
      e.r[k] = m_res[k];
      e.c[k] = m_co[k];
    end
    e.req = req;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        for (int k = 0; k < 3; k++) begin
          checks++;
          if (res[k] !== e.r[k] || co[k] !== e.c[k]) begin
            fails++;
            $display("FAIL %s lanes=%0d: result=%h carry=%b expected result=%h carry=%b",
                     e.req, 1 << k, res[k], co[k], e.r[k], e.c[k]);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    for (int k = 0; k < 3; k++) begin
      m_res[k] = '0;
      m_co[k]  = '0;
    end
    step(1, 0, 3'b000, 48'h123456789ABC, 48'h1, 1, "R9");
    step(1, 1, 3'b000, 48'hFFFFFFFFFFFF, 48'h1, 0, "R9");
    // lane boundaries: carry ripples fully only in the single-lane build
    step(0, 1, 3'b000, 48'hFFFFFFFFFFFF, 48'h000000000001, 0, "R1");
    step(0, 1, 3'b000, 48'h000FFF000FFF, 48'h000000000000, 1, "R2");
    step(0, 1, 3'b000, 48'h7FF7FF7FF7FF, 48'h801801801801, 0, "R2");
    step(0, 1, 3'b000, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 1, "R5");
    step(0, 1, 3'b001, 48'h000000000005, 48'h000000000007, 0, "R3");
    step(0, 1, 3'b001, 48'h001000001000, 48'h000001000001, 1, "R3");
    step(0, 1, 3'b001, 48'h555555555555, 48'h555555555555, 0, "R5");
    // accumulate chain from a cleared register
    step(1, 0, 3'b000, '0, '0, 0, "R9");
    step(0, 1, 3'b010, '0, 48'h800800800800, 0, "R4");
    step(0, 1, 3'b010, '0, 48'h800800800800, 1, "R4");
    step(0, 1, 3'b010, '0, 48'hFFFFFFFFFFFF, 0, "R4");
    // logic ops: identical across lane modes, carry cleared
    step(0, 1, 3'b011, 48'hF0F0_FFFF_0000, 48'hFF00_0FF0_1234, 1, "R6");
    step(0, 1, 3'b100, 48'hF0F0_FFFF_0000, 48'hFF00_0FF0_1234, 0, "R6");
    step(0, 1, 3'b101, 48'hF0F0_FFFF_0000, 48'hFF00_0FF0_1234, 0, "R6");
    step(0, 1, 3'b110, 48'hF0F0_FFFF_0000, 48'hFF00_0FF0_1234, 1, "R6");
    step(0, 1, 3'b111, 48'hF0F0_FFFF_0000, 48'hFF00_0FF0_1234, 0, "R6");
    // hold with enable low
    step(0, 1, 3'b000, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 0, "R7");
    step(0, 0, 3'b011, 48'h0, 48'h0, 0, "R8");
    step(0, 0, 3'b010, 48'h1, 48'h1, 1, "R8");
    step(1, 1, 3'b000, 48'hFFFFFFFFFFFF, 48'h1, 1, "R9");
    for (int n = 0; n < 60; n++) begin
      step(0, ($urandom % 5) != 0, 3'($urandom),
           {$urandom, $urandom} & 48'hFFFFFFFFFFFF,
           {$urandom, $urandom} & 48'hFFFFFFFFFFFF, 1'($urandom), "R7");
    end
    @(negedge clk);
    ce = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule